// File: doc/BRIEF.md
# Paged Flash Window Address Mapper

This block sits between a CPU with a 16-bit address bus and the memories of a microcontroller whose program flash (eight pages of 16 KB, page numbers 0x38 to 0x3F) is larger than the address space. Each cycle it decodes the CPU address, with no register in the path, into one of four target selects: register block, RAM, EEPROM or flash. For flash accesses it also produces a 17-bit physical address.

Two 16 KB flash pages are permanently visible. 0x4000–0x7FFF always shows page 0x3E and 0xC000–0xFFFF always shows page 0x3F. The 16 KB range 0x8000–0xBFFF is a window. A 6-bit page register, located at offset 0x30 inside the register block, chooses which page the window shows. The base addresses of the register block, RAM and EEPROM are configuration inputs, so these regions may overlap each other or the flash. A fixed precedence order decides which target wins an overlap. A window access whose page number is not implemented selects nothing and raises an error flag.

Top module: `pgwin_mapper`

## Requirements
- R1: While a strobe is active, an address in 0x4000–0x7FFF that no higher region claims asserts sel_flash, with flash_addr = {3'b110, addr[13:0]}. This mapping does not depend on the page register.
- R2: While a strobe is active, an address in 0xC000–0xFFFF that no higher region claims asserts sel_flash, with flash_addr = {3'b111, addr[13:0]}.
- R3: While a strobe is active, an address in 0x8000–0xBFFF whose page register value lies in 0x38–0x3F asserts sel_flash, with flash_addr = {page[2:0], addr[13:0]}.
- R4: The page register sits at cfg_reg_base + 0x30. A write there stores cpu_wdata[5:0]. page_rdata always shows {2'b00, page}. An active-low reset clears the page to 0x00.
- R5: A page write takes effect at the next rising clock edge. During the write cycle, page_rdata and the window mapping still use the old page.
- R6: A window access that no higher region claims, made while the page is outside 0x38–0x3F, drives page_err high and sel_flash low.
- R7: The register block spans [cfg_reg_base, +1 KB), RAM spans [cfg_ram_base, +8 KB) and EEPROM spans [cfg_ee_base, +2 KB). An access that falls inside one of these ranges asserts that range's select.
- R8: Precedence from highest to lowest is register block, RAM, EEPROM, flash. At most one select is ever high. An access that hits none of the four regions asserts no select.
- R9: When cpu_rd and cpu_wr are both low, all selects and page_err are low and the page register does not change.
- R10: flash_addr is zero whenever sel_flash is low.
- R11: A write to any address other than the page register address leaves the page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cfg_reg_base | input | 16 | Base address of the register block |
| cfg_ram_base | input | 16 | Base address of RAM |
| cfg_ee_base | input | 16 | Base address of EEPROM |
| sel_reg | output | 1 | Register block select |
| sel_ram | output | 1 | RAM select |
| sel_eep | output | 1 | EEPROM select |
| sel_flash | output | 1 | Flash select |
| flash_addr | output | 17 | Physical flash address |
| page_err | output | 1 | Window access to an unimplemented page |
| page_rdata | output | 8 | Page register readback |

## Verification
Two things can happen in the same cycle: a CPU write updating the page register, and the window translation that depends on the current page. The bench issues a page write and checks, in that same cycle before the clock edge, that page_rdata still holds the old value. It then runs window reads in the following cycles and checks that flash_addr and page_err follow the new value. Precedence is exercised by moving the configurable bases so that regions overlap, then checking that only the winning select is asserted and that a RAM region covering the window suppresses the page error.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;

    localparam int PGW_ADDR_W = 16;
    localparam int PGW_DATA_W = 8;
    localparam int PGW_PAGE_W = 6;
    localparam int PGW_OFF_W  = 14;
    localparam int PGW_N_TGT  = 4;

    // select vector order is also the precedence order (index 0 highest)
    typedef enum logic [1:0] {
        TGT_REG   = 2'd0,
        TGT_RAM   = 2'd1,
        TGT_EEP   = 2'd2,
        TGT_FLASH = 2'd3
    } tgt_e;

    typedef struct packed {
        logic [PGW_PAGE_W-1:0] page;
    } page_state_t;

endpackage

// File: rtl/pgwin_region_hit.sv
module pgwin_region_hit #(
    parameter int ADDR_W = 16,
    parameter int SIZE   = 1024
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    output logic              hit
);
    localparam logic [ADDR_W:0] SIZE_X = (ADDR_W+1)'(SIZE);

    logic [ADDR_W:0] rel;

    always_comb begin
        // a negative distance wraps to a large value and fails the compare
        rel = {1'b0, addr} - {1'b0, base};
        hit = (rel < SIZE_X);
    end
endmodule

// File: rtl/pgwin_page_reg.sv
module pgwin_page_reg
    import pgwin_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [PGW_PAGE_W-1:0] wdata,
    output logic [PGW_PAGE_W-1:0] page
);
    page_state_t st_d;
    page_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.page = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign page = st_q.page;
endmodule

// File: rtl/pgwin_flash_xlat.sv
module pgwin_flash_xlat
    import pgwin_pkg::*;
#(
    parameter logic [PGW_PAGE_W-1:0] FIRST_PAGE = 6'h38,
    parameter logic [PGW_PAGE_W-1:0] LAST_PAGE  = 6'h3F,
    parameter logic [PGW_PAGE_W-1:0] LO_PAGE    = 6'h3E,
    parameter logic [PGW_PAGE_W-1:0] HI_PAGE    = 6'h3F,
    parameter int                    IDX_W      = 3
) (
    input  logic [PGW_ADDR_W-1:0]      addr,
    input  logic [PGW_PAGE_W-1:0]      page_q,
    output logic                       flash_hit,
    output logic                       win_err,
    output logic [IDX_W+PGW_OFF_W-1:0] phys
);
    localparam int QW = PGW_ADDR_W - PGW_OFF_W;
    localparam logic [QW-1:0] Q_LO  = QW'(1);
    localparam logic [QW-1:0] Q_WIN = QW'(2);
    localparam logic [QW-1:0] Q_HI  = QW'(3);

    logic [QW-1:0]         quarter;
    logic                  in_lo;
    logic                  in_win;
    logic                  in_hi;
    logic [PGW_PAGE_W-1:0] page_sel;
    logic [PGW_PAGE_W-1:0] idx_full;
    logic                  page_ok;
    logic                  unused_idx_hi;

    always_comb begin
        quarter  = addr[PGW_ADDR_W-1:PGW_OFF_W];
        in_lo    = (quarter == Q_LO);
        in_win   = (quarter == Q_WIN);
        in_hi    = (quarter == Q_HI);
        page_sel = in_lo ? LO_PAGE : (in_hi ? HI_PAGE : page_q);
        page_ok  = (page_sel >= FIRST_PAGE) && (page_sel <= LAST_PAGE);
        idx_full = page_sel - FIRST_PAGE;
        flash_hit = (in_lo || in_hi || in_win) && page_ok;
        win_err   = in_win && !page_ok;
        phys      = {idx_full[IDX_W-1:0], addr[PGW_OFF_W-1:0]};
    end

    assign unused_idx_hi = ^idx_full[PGW_PAGE_W-1:IDX_W];
endmodule

// File: rtl/pgwin_prio.sv
module pgwin_prio #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic taken;

    always_comb begin
        gnt   = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pgwin_mapper.sv
module pgwin_mapper
    import pgwin_pkg::*;
#(
    parameter int                    REG_SIZE     = 1024,
    parameter int                    RAM_SIZE     = 8192,
    parameter int                    EEP_SIZE     = 2048,
    parameter int                    FLASH_PAGES  = 8,
    parameter logic [PGW_PAGE_W-1:0] FIRST_PAGE   = 6'h38,
    parameter logic [PGW_PAGE_W-1:0] LO_PAGE      = 6'h3E,
    parameter logic [PGW_PAGE_W-1:0] HI_PAGE      = 6'h3F,
    parameter logic [PGW_ADDR_W-1:0] PAGE_REG_OFS = 16'h0030
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [PGW_ADDR_W-1:0]                       cpu_addr,
    input  logic [PGW_DATA_W-1:0]                       cpu_wdata,
    input  logic                                        cpu_rd,
    input  logic                                        cpu_wr,
    input  logic [PGW_ADDR_W-1:0]                       cfg_reg_base,
    input  logic [PGW_ADDR_W-1:0]                       cfg_ram_base,
    input  logic [PGW_ADDR_W-1:0]                       cfg_ee_base,
    output logic                                        sel_reg,
    output logic                                        sel_ram,
    output logic                                        sel_eep,
    output logic                                        sel_flash,
    output logic [PGW_OFF_W+$clog2(FLASH_PAGES)-1:0]    flash_addr,
    output logic                                        page_err,
    output logic [PGW_DATA_W-1:0]                       page_rdata
);
    localparam int IDX_W    = $clog2(FLASH_PAGES);
    localparam int FLASH_AW = PGW_OFF_W + IDX_W;
    localparam logic [PGW_PAGE_W-1:0] LAST_PAGE = FIRST_PAGE + PGW_PAGE_W'(FLASH_PAGES - 1);
    localparam int N_INT = 3;
    localparam int INT_SIZE [N_INT] = '{REG_SIZE, RAM_SIZE, EEP_SIZE};

    logic [PGW_ADDR_W-1:0] int_base [N_INT];
    logic [N_INT-1:0]      int_hit;
    logic                  fl_hit;
    logic                  fl_win_err;
    logic [FLASH_AW-1:0]   fl_phys;
    logic [PGW_PAGE_W-1:0] page_q;
    logic                  access;
    logic [PGW_N_TGT-1:0]  req;
    logic [PGW_N_TGT-1:0]  gnt;
    logic                  page_we;
    logic [PGW_ADDR_W-1:0] page_reg_addr;
    logic                  unused_wdata_hi;

    assign int_base[TGT_REG] = cfg_reg_base;
    assign int_base[TGT_RAM] = cfg_ram_base;
    assign int_base[TGT_EEP] = cfg_ee_base;

    for (genvar g = 0; g < N_INT; g++) begin : g_region
        pgwin_region_hit #(
            .ADDR_W (PGW_ADDR_W),
            .SIZE   (INT_SIZE[g])
        ) u_hit (
            .addr (cpu_addr),
            .base (int_base[g]),
            .hit  (int_hit[g])
        );
    end

    pgwin_flash_xlat #(
        .FIRST_PAGE (FIRST_PAGE),
        .LAST_PAGE  (LAST_PAGE),
        .LO_PAGE    (LO_PAGE),
        .HI_PAGE    (HI_PAGE),
        .IDX_W      (IDX_W)
    ) u_xlat (
        .addr      (cpu_addr),
        .page_q    (page_q),
        .flash_hit (fl_hit),
        .win_err   (fl_win_err),
        .phys      (fl_phys)
    );

    pgwin_prio #(
        .N (PGW_N_TGT)
    ) u_prio (
        .req (req),
        .gnt (gnt)
    );

    always_comb begin
        access        = cpu_rd || cpu_wr;
        req           = {fl_hit, int_hit} & {PGW_N_TGT{access}};
        page_reg_addr = cfg_reg_base + PAGE_REG_OFS;
        page_we       = cpu_wr && gnt[TGT_REG] && (cpu_addr == page_reg_addr);
        sel_reg       = gnt[TGT_REG];
        sel_ram       = gnt[TGT_RAM];
        sel_eep       = gnt[TGT_EEP];
        sel_flash     = gnt[TGT_FLASH];
        // a window miss only matters when no internal region claims the access
        page_err      = access && fl_win_err && (int_hit == '0);
        flash_addr    = gnt[TGT_FLASH] ? fl_phys : '0;
        page_rdata    = {{(PGW_DATA_W-PGW_PAGE_W){1'b0}}, page_q};
    end

    pgwin_page_reg u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (page_we),
        .wdata (cpu_wdata[PGW_PAGE_W-1:0]),
        .page  (page_q)
    );

    assign unused_wdata_hi = ^cpu_wdata[PGW_DATA_W-1:PGW_PAGE_W];
endmodule

// File: rtl/pgwin_mapper_sva.sv
module pgwin_mapper_sva #(
    parameter logic [15:0] PAGE_REG_OFS = 16'h0030
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic [15:0] cfg_reg_base,
    input logic        sel_reg,
    input logic        sel_ram,
    input logic        sel_eep,
    input logic        sel_flash,
    input logic [16:0] flash_addr,
    input logic        page_err,
    input logic [7:0]  page_rdata
);
    logic        pg_write;
    logic [15:0] pg_addr;

    assign pg_addr  = cfg_reg_base + PAGE_REG_OFS;
    assign pg_write = cpu_wr && sel_reg && (cpu_addr == pg_addr);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_reg, sel_ram, sel_eep, sel_flash})); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd || cpu_wr) |-> !(sel_reg || sel_ram || sel_eep || sel_flash || page_err)); // R9

    AST_ERR_NO_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |-> (!sel_flash && cpu_addr[15:14] == 2'b10)); // R6

    AST_LO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_flash && cpu_addr[15:14] == 2'b01) |-> flash_addr[16:14] == 3'b110); // R1

    AST_HI_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_flash && cpu_addr[15:14] == 2'b11) |-> flash_addr[16:14] == 3'b111); // R2

    AST_WIN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_flash && cpu_addr[15:14] == 2'b10) |-> flash_addr[16:14] == page_rdata[2:0]); // R3

    AST_FADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_flash |-> flash_addr == 17'd0); // R10

    AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        pg_write |=> page_rdata == {2'b00, $past(cpu_wdata[5:0])}); // R5

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_write |=> $stable(page_rdata)); // R11

    AST_PAGE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        page_rdata[7:6] == 2'b00); // R4
endmodule

bind pgwin_mapper pgwin_mapper_sva u_sva (.*);

// File: tb/pgwin_mapper_test.sv
module pgwin_mapper_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cfg_reg_base = 16'h0000;
    logic [15:0] cfg_ram_base = 16'h2000;
    logic [15:0] cfg_ee_base  = 16'h0800;
    logic        sel_reg, sel_ram, sel_eep, sel_flash;
    logic [16:0] flash_addr;
    logic        page_err;
    logic [7:0]  page_rdata;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    pgwin_mapper uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_rd       (cpu_rd),
        .cpu_wr       (cpu_wr),
        .cfg_reg_base (cfg_reg_base),
        .cfg_ram_base (cfg_ram_base),
        .cfg_ee_base  (cfg_ee_base),
        .sel_reg      (sel_reg),
        .sel_ram      (sel_ram),
        .sel_eep      (sel_eep),
        .sel_flash    (sel_flash),
        .flash_addr   (flash_addr),
        .page_err     (page_err),
        .page_rdata   (page_rdata)
    );

    // row: addr, rd, wr, wdata, sel{reg,ram,eep,flash}, flash_addr, err, page_rdata, req
    localparam int NV = 28;
    localparam logic [63:0] VECS [NV] = '{
        {16'h4000, 1'b1, 1'b0, 8'h00, 4'b0001, 17'h18000, 1'b0, 8'h00, 8'd1},  // R1
        {16'h7FFF, 1'b1, 1'b0, 8'h00, 4'b0001, 17'h1BFFF, 1'b0, 8'h00, 8'd1},  // R1
        {16'hC000, 1'b1, 1'b0, 8'h00, 4'b0001, 17'h1C000, 1'b0, 8'h00, 8'd2},  // R2
        {16'hFFFF, 1'b1, 1'b0, 8'h00, 4'b0001, 17'h1FFFF, 1'b0, 8'h00, 8'd2},  // R2
        {16'h8000, 1'b1, 1'b0, 8'h00, 4'b0000, 17'h00000, 1'b1, 8'h00, 8'd6},  // R6
        {16'h0030, 1'b0, 1'b1, 8'hFA, 4'b1000, 17'h00000, 1'b0, 8'h00, 8'd5},  // R5
        {16'h8000, 1'b1, 1'b0, 8'h00, 4'b0001, 17'h08000, 1'b0, 8'h3A, 8'd3},  // R3
        {16'hBFFF, 1'b1, 1'b0, 8'h00, 4'b0001, 17'h0BFFF, 1'b0, 8'h3A, 8'd3},  // R3
        {16'h0030, 1'b1, 1'b0, 8'h00, 4'b1000, 17'h00000, 1'b0, 8'h3A, 8'd4},  // R4
        {16'h2000, 1'b1, 1'b0, 8'h00, 4'b0100, 17'h00000, 1'b0, 8'h3A, 8'd7},  // R7
        {16'h3FFF, 1'b1, 1'b0, 8'h00, 4'b0100, 17'h00000, 1'b0, 8'h3A, 8'd7},  // R7
        {16'h0800, 1'b1, 1'b0, 8'h00, 4'b0010, 17'h00000, 1'b0, 8'h3A, 8'd7},  // R7
        {16'h0FFF, 1'b1, 1'b0, 8'h00, 4'b0010, 17'h00000, 1'b0, 8'h3A, 8'd7},  // R7
        {16'h03FF, 1'b1, 1'b0, 8'h00, 4'b1000, 17'h00000, 1'b0, 8'h3A, 8'd7},  // R7
        {16'h0400, 1'b1, 1'b0, 8'h00, 4'b0000, 17'h00000, 1'b0, 8'h3A, 8'd8},  // R8
        {16'h1000, 1'b1, 1'b0, 8'h00, 4'b0000, 17'h00000, 1'b0, 8'h3A, 8'd8},  // R8
        {16'h4000, 1'b0, 1'b0, 8'h00, 4'b0000, 17'h00000, 1'b0, 8'h3A, 8'd9},  // R9
        {16'h0031, 1'b0, 1'b1, 8'h05, 4'b1000, 17'h00000, 1'b0, 8'h3A, 8'd11}, // R11
        {16'h8123, 1'b1, 1'b0, 8'h00, 4'b0001, 17'h08123, 1'b0, 8'h3A, 8'd11}, // R11
        {16'h0030, 1'b0, 1'b1, 8'h3F, 4'b1000, 17'h00000, 1'b0, 8'h3A, 8'd4},  // R4
        {16'h9000, 1'b1, 1'b0, 8'h00, 4'b0001, 17'h1D000, 1'b0, 8'h3F, 8'd3},  // R3
        {16'h0030, 1'b0, 1'b1, 8'h37, 4'b1000, 17'h00000, 1'b0, 8'h3F, 8'd5},  // R5
        {16'h8000, 1'b1, 1'b0, 8'h00, 4'b0000, 17'h00000, 1'b1, 8'h37, 8'd6},  // R6
        {16'h0030, 1'b0, 1'b0, 8'h00, 4'b0000, 17'h00000, 1'b0, 8'h37, 8'd9},  // R9
        {16'h8000, 1'b1, 1'b0, 8'h00, 4'b0000, 17'h00000, 1'b1, 8'h37, 8'd9},  // R9
        {16'h0030, 1'b0, 1'b1, 8'h38, 4'b1000, 17'h00000, 1'b0, 8'h37, 8'd4},  // R4
        {16'hA000, 1'b1, 1'b0, 8'h00, 4'b0001, 17'h02000, 1'b0, 8'h38, 8'd3},  // R3
        {16'h4000, 1'b1, 1'b0, 8'h00, 4'b0001, 17'h18000, 1'b0, 8'h38, 8'd1}   // R1
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive at the falling edge, leave settle time, sample well before the rising edge
    task automatic apply(input logic [15:0] a, input logic r, input logic w,
                         input logic [7:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_rd    = r;
        cpu_wr    = w;
        cpu_wdata = d;
        #5;
    endtask

    function automatic logic [31:0] sels();
        return {28'd0, sel_reg, sel_ram, sel_eep, sel_flash};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk("R4", "page after reset", page_rdata, 8'h00);
        chk("R9", "selects during reset idle", sels(), 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string rq;
            logic [63:0] v;
            v  = VECS[i];
            rq = $sformatf("R%0d", v[7:0]);
            apply(v[63:48], v[47], v[46], v[45:38]);
            chk(rq, $sformatf("row %0d selects", i), sels(), {28'd0, v[37:34]});
            chk(rq, $sformatf("row %0d flash_addr", i), {15'd0, flash_addr}, {15'd0, v[33:17]});
            chk(rq, $sformatf("row %0d page_err", i), {31'd0, page_err}, {31'd0, v[16]});
            chk(rq, $sformatf("row %0d page_rdata", i), {24'd0, page_rdata}, {24'd0, v[15:8]});
        end
        apply(16'h0000, 1'b0, 1'b0, 8'h00);

        // R4: asynchronous reset clears the page mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        chk("R4", "page cleared by reset", page_rdata, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: register block over RAM
        cfg_ram_base = 16'h0000;
        apply(16'h0010, 1'b1, 1'b0, 8'h00);
        chk("R8", "reg wins over ram", sels(), 4'b1000);
        apply(16'h0500, 1'b1, 1'b0, 8'h00);
        chk("R7", "ram at moved base", sels(), 4'b0100);
        // R8: RAM over EEPROM
        cfg_ee_base = 16'h0000;
        apply(16'h0600, 1'b1, 1'b0, 8'h00);
        chk("R8", "ram wins over eeprom", sels(), 4'b0100);
        cfg_ram_base = 16'h2000;
        apply(16'h0600, 1'b1, 1'b0, 8'h00);
        chk("R8", "eeprom alone", sels(), 4'b0010);
        apply(16'h0010, 1'b1, 1'b0, 8'h00);
        chk("R8", "reg wins over eeprom", sels(), 4'b1000);
        // R8 / R10: EEPROM over fixed flash
        cfg_ee_base = 16'h4000;
        apply(16'h4100, 1'b1, 1'b0, 8'h00);
        chk("R8", "eeprom wins over flash", sels(), 4'b0010);
        chk("R10", "flash_addr zero without flash select", {15'd0, flash_addr}, 32'd0);
        apply(16'h4900, 1'b1, 1'b0, 8'h00);
        chk("R1", "flash past eeprom end", sels(), 4'b0001);
        chk("R1", "flash_addr past eeprom end", {15'd0, flash_addr}, 32'h18900);
        // R6: RAM covering the window hides the bad-page error
        cfg_ram_base = 16'h8000;
        apply(16'h8000, 1'b1, 1'b0, 8'h00);
        chk("R6", "ram over window no error", {31'd0, page_err}, 32'd0);
        chk("R8", "ram over window select", sels(), 4'b0100);
        apply(16'hA000, 1'b1, 1'b0, 8'h00);
        chk("R6", "bad page error past ram", {31'd0, page_err}, 32'd1);
        chk("R6", "no select on bad page", sels(), 4'b0000);
        // R4 / R11: page register follows the register block base
        cfg_reg_base = 16'h1000;
        apply(16'h1030, 1'b0, 1'b1, 8'h3C);
        chk("R5", "old page in write cycle", page_rdata, 8'h00);
        apply(16'h0000, 1'b0, 1'b0, 8'h00);
        chk("R4", "page at moved register base", page_rdata, 8'h3C);
        apply(16'h0030, 1'b0, 1'b1, 8'h39);
        chk("R11", "old address now unmapped", sels(), 4'b0000);
        apply(16'h0000, 1'b0, 1'b0, 8'h00);
        chk("R11", "page kept after stray write", page_rdata, 8'h3C);
        cfg_ram_base = 16'h2000;
        apply(16'h8004, 1'b1, 1'b0, 8'h00);
        chk("R3", "window page 3C select", sels(), 4'b0001);
        chk("R3", "window page 3C address", {15'd0, flash_addr}, 32'h10004);
        apply(16'h0000, 1'b0, 1'b0, 8'h00);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule